// File: doc/BRIEF.md
# Guest Boot-Remap Address Decoder

This block turns the bus cycles of one guest 68000-family processor into chip selects for three targets: a local SRAM, a 2 KB dual-port mailbox RAM shared with a host, and a boot ROM. The host owns a one-bit placement flag. The flag places the mailbox window either at the bottom of memory, where it overrides SRAM, or in a region at a fixed high base. Inside that high region the 2 KB window repeats every 2 KB.

The decoder also knows about the reset-vector fetch. The processor reads its initial stack pointer and initial program counter from the first 8 bytes, and it is the only access made with function code 110 (supervisor program). All other vector reads use 101 (supervisor data). A two-bit boot option can send those 8 bytes to the ROM or to the mailbox RAM for the 110 fetch only. Every other access to those bytes follows the normal map.

Chip selects are registered and appear one clock after the cycle's inputs are sampled. The placement flag is captured only while the address strobe is idle, so it never changes in the middle of a bus cycle.

Top module: `boot_map_decoder`

## Requirements
- R1: No chip select is asserted in the cycle after a clock edge at which the address strobe `as_ni` was high (inactive).
- R2: No chip select is asserted in the cycle after an edge at which `fc_i` was 3'b111 (interrupt acknowledge).
- R3: At most one of `sram_cs_o`, `dpram_cs_o`, `rom_cs_o` is high in any cycle.
- R4: Each chip select is registered. The value after a rising edge is decoded from the address, function code, strobe and boot option present at that edge.
- R5: When the captured placement flag is 1, any address in 0x000000–0x0007FF selects the mailbox RAM, and SRAM is not selected there.
- R6: When the captured flag is 0, the mailbox RAM is selected across 0x080000–0x08FFFF, where the 2 KB window repeats every 2 KB. SRAM alone owns 0x000000–0x0007FF.
- R7: Outside the mailbox window and the boot override, addresses 0x000000–0x07FFFF select SRAM.
- R8: Addresses 0x C00000–0x C0FFFF select the ROM. 0x BFFFFF, 0x C10000 and any address outside all regions select nothing.
- R9: With `fc_i` = 3'b110 and address 0–7, boot option 2'b01 selects the ROM and 2'b10 selects the mailbox RAM. Option 2'b00 or 2'b11 leaves the normal map in force.
- R10: The boot option has no effect when the function code is not 3'b110, or when the address is 8 or higher.
- R11: The placement flag `map_low_i` is captured only at edges where `as_ni` is high. From the next edge on, the captured value governs decoding. A change made while the strobe stays active has no effect.
- R12: While `rst_ni` is low, all chip selects are low. The captured placement flag resets to 1 (window low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Guest clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 24 | Guest byte address |
| fc_i | input | 3 | Processor function code (bit 2 = FC2) |
| as_ni | input | 1 | Address strobe, active low |
| map_low_i | input | 1 | Host placement flag: 1 = window at 0, 0 = window at high base |
| boot_mode_i | input | 2 | Boot override: 00 off, 01 ROM, 10 mailbox RAM, 11 off |
| sram_cs_o | output | 1 | Local SRAM select |
| dpram_cs_o | output | 1 | Mailbox RAM select |
| rom_cs_o | output | 1 | Boot ROM select |

## Verification
Every chip select is due exactly one clock after the edge that samples its inputs. The bench drives inputs just after a falling edge and compares outputs at the following falling edge, which is the first point where that edge's result is visible. The placement flag has a further step. A value presented while the strobe is idle is taken at that edge and affects decoding only from the next edge. The reference model therefore keeps its own captured flag, updates it after it computes the expected selects, and so reproduces the two-stage timing without looking inside the design.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef enum logic [1:0] {
    BOOT_NONE  = 2'b00,
    BOOT_ROM   = 2'b01,
    BOOT_DPRAM = 2'b10,
    BOOT_RSVD  = 2'b11
  } boot_mode_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_SRAM,
    TGT_DPRAM,
    TGT_ROM
  } target_e;

  localparam logic [2:0] FC_SUP_PROG = 3'b110;
  localparam logic [2:0] FC_IACK     = 3'b111;

  // region indices into the hit vector
  localparam int RG_SRAM  = 0;
  localparam int RG_DP_LO = 1;
  localparam int RG_DP_HI = 2;
  localparam int RG_ROM   = 3;
  localparam int RG_BOOT  = 4;
  localparam int NUM_RG   = 5;
endpackage

// File: rtl/bmd_region_match.sv
// Power-of-two, size-aligned region compare; everything inside aliases freely.
module bmd_region_match #(
  parameter int          ADDR_W = 24,
  parameter logic [31:0] BASE   = 32'h0,
  parameter logic [31:0] BYTES  = 32'h800
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] MASK   = ~ADDR_W'(BYTES - 32'd1);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  assign hit_o = (addr_i & MASK) == BASE_A;
endmodule

// File: rtl/bmd_map_hold.sv
module bmd_map_hold #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_ni,
  input  logic map_low_i,
  output logic map_low_q_o
);
  // only load between bus cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    map_low_q_o <= RST_VAL;
    else if (as_ni) map_low_q_o <= map_low_i;
  end

  assert_map_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_ni |=> $stable(map_low_q_o));

  assert_map_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> map_low_q_o == $past(map_low_i));
endmodule

// File: rtl/bmd_cs_select.sv
module bmd_cs_select
  import bmd_pkg::*;
#(
  parameter int N_RG = NUM_RG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_RG-1:0] hit_i,
  input  logic [2:0]      fc_i,
  input  logic            as_ni,
  input  logic            map_low_i,
  input  boot_mode_e      boot_mode_i,
  output logic            sram_cs_o,
  output logic            dpram_cs_o,
  output logic            rom_cs_o
);
  target_e tgt;
  logic    boot_fetch;

  assign boot_fetch = (fc_i == FC_SUP_PROG) && hit_i[RG_BOOT];

  always_comb begin
    tgt = TGT_NONE;
    if (!as_ni && fc_i != FC_IACK) begin
      if (boot_fetch && boot_mode_i == BOOT_ROM)        tgt = TGT_ROM;
      else if (boot_fetch && boot_mode_i == BOOT_DPRAM) tgt = TGT_DPRAM;
      else if (map_low_i ? hit_i[RG_DP_LO] : hit_i[RG_DP_HI]) tgt = TGT_DPRAM;
      else if (hit_i[RG_SRAM])                          tgt = TGT_SRAM;
      else if (hit_i[RG_ROM])                           tgt = TGT_ROM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_cs_o  <= 1'b0;
      dpram_cs_o <= 1'b0;
      rom_cs_o   <= 1'b0;
    end else begin
      sram_cs_o  <= (tgt == TGT_SRAM);
      dpram_cs_o <= (tgt == TGT_DPRAM);
      rom_cs_o   <= (tgt == TGT_ROM);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> !(sram_cs_o || dpram_cs_o || rom_cs_o));

  assert_iack_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_i == FC_IACK) |=> !(sram_cs_o || dpram_cs_o || rom_cs_o));

  assert_single_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sram_cs_o, dpram_cs_o, rom_cs_o}));

  assert_boot_rom_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_ni && boot_fetch && boot_mode_i == BOOT_ROM) |=> rom_cs_o);

  assert_low_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_ni && fc_i != FC_SUP_PROG && fc_i != FC_IACK && map_low_i && hit_i[RG_DP_LO])
      |=> dpram_cs_o && !sram_cs_o);
endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
  import bmd_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter logic [31:0] SRAM_BASE  = 32'h000000,
  parameter logic [31:0] SRAM_BYTES = 32'h080000,
  parameter logic [31:0] DP_BYTES   = 32'h000800,
  parameter logic [31:0] DP_HI_BASE = 32'h080000,
  parameter logic [31:0] DP_HI_SPAN = 32'h010000,
  parameter logic [31:0] ROM_BASE   = 32'hC00000,
  parameter logic [31:0] ROM_BYTES  = 32'h010000,
  parameter logic [31:0] BOOT_BYTES = 32'h000008,
  parameter logic        MAP_RST    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              as_ni,
  input  logic              map_low_i,
  input  logic [1:0]        boot_mode_i,
  output logic              sram_cs_o,
  output logic              dpram_cs_o,
  output logic              rom_cs_o
);
  localparam logic [31:0] RG_BASE [NUM_RG] =
    '{SRAM_BASE, 32'h0, DP_HI_BASE, ROM_BASE, 32'h0};
  localparam logic [31:0] RG_BYTES[NUM_RG] =
    '{SRAM_BYTES, DP_BYTES, DP_HI_SPAN, ROM_BYTES, BOOT_BYTES};

  logic [NUM_RG-1:0] hit;
  logic              map_low_q;

  for (genvar g = 0; g < NUM_RG; g++) begin : g_rg
    bmd_region_match #(
      .ADDR_W(ADDR_W),
      .BASE  (RG_BASE[g]),
      .BYTES (RG_BYTES[g])
    ) u_match (
      .addr_i(addr_i),
      .hit_o (hit[g])
    );
  end

  bmd_map_hold #(.RST_VAL(MAP_RST)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .as_ni      (as_ni),
    .map_low_i  (map_low_i),
    .map_low_q_o(map_low_q)
  );

  bmd_cs_select #(.N_RG(NUM_RG)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .fc_i       (fc_i),
    .as_ni      (as_ni),
    .map_low_i  (map_low_q),
    .boot_mode_i(boot_mode_e'(boot_mode_i)),
    .sram_cs_o  (sram_cs_o),
    .dpram_cs_o (dpram_cs_o),
    .rom_cs_o   (rom_cs_o)
  );
endmodule

// File: tb/test_boot_map_decoder.sv
module test_boot_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] addr;
  logic [2:0]  fc;
  logic        as_n;
  logic        map_low;
  logic [1:0]  boot;
  logic        sram_cs, dpram_cs, rom_cs;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  boot_map_decoder i_boot_map_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .fc_i(fc), .as_ni(as_n),
    .map_low_i(map_low), .boot_mode_i(boot),
    .sram_cs_o(sram_cs), .dpram_cs_o(dpram_cs), .rom_cs_o(rom_cs)
  );

  // reference: returns {rom, dpram, sram}
  function automatic logic [2:0] ref_cs(int unsigned a, int f, bit idle, int bm, bit low);
    if (idle || f == 7)                         return 3'b000;
    if (f == 6 && a < 8 && bm == 1)             return 3'b100;
    if (f == 6 && a < 8 && bm == 2)             return 3'b010;
    if (low && a < 32'h800)                     return 3'b010;
    if (!low && a >= 32'h80000 && a < 32'h90000) return 3'b010;
    if (a < 32'h80000)                          return 3'b001;
    if (a >= 32'hC00000 && a < 32'hC10000)      return 3'b100;
    return 3'b000;
  endfunction

  logic [2:0] exp_cs;
  bit         map_eff;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_cs  <= 3'b000;
      map_eff <= 1'b1;
    end else begin
      exp_cs <= ref_cs(addr, fc, as_n, boot, map_eff);
      if (as_n) map_eff <= map_low;
    end
  end

  task automatic compare(string tag);
    logic [2:0] got;
    got = {rom_cs, dpram_cs, sram_cs};
    n_cmp++;
    if (got !== exp_cs) begin
      n_bad++;
      $display("FAIL %s addr=%h fc=%0d as_n=%0b boot=%0d: cs got %b expected %b",
               tag, addr, fc, as_n, boot, got, exp_cs);
    end
    n_cmp++;
    if ($countones(got) > 1) begin
      n_bad++;
      $display("FAIL R3 more than one select: got %b expected at most one", got);
    end
  endtask

  task automatic drive(logic [23:0] a, logic [2:0] f, logic idle, logic [1:0] bm, string tag);
    addr = a; fc = f; as_n = idle; boot = bm;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic access(logic [23:0] a, logic [2:0] f, logic [1:0] bm, string tag);
    drive(a, f, 1'b1, bm, tag);
    drive(a, f, 1'b0, bm, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; map_low = 1'b0;
    addr = 24'h0; fc = 3'd5; as_n = 1'b0; boot = 2'b00;
    // R12: selects held low, flag resets to low window
    repeat (4) drive(24'h000000, 3'd5, 1'b0, 2'b00, "R12");
    rst_n = 1'b1;
    map_low = 1'b1;
    drive(24'h000100, 3'd5, 1'b0, 2'b00, "R12");   // flag came from reset
    // R5 low window
    access(24'h000000, 3'd5, 2'b00, "R5");
    access(24'h0007FE, 3'd1, 2'b00, "R5");
    access(24'h000800, 3'd5, 2'b00, "R5");
    access(24'h080000, 3'd5, 2'b00, "R5");
    // R6 high window
    map_low = 1'b0;
    access(24'h080000, 3'd5, 2'b00, "R6");
    access(24'h080802, 3'd1, 2'b00, "R6");
    access(24'h08FFFE, 3'd5, 2'b00, "R6");
    access(24'h090000, 3'd5, 2'b00, "R6");
    access(24'h000000, 3'd5, 2'b00, "R6");
    access(24'h0007FF, 3'd2, 2'b00, "R6");
    // R7 SRAM
    access(24'h000800, 3'd5, 2'b00, "R7");
    access(24'h07FFFE, 3'd1, 2'b00, "R7");
    access(24'h040000, 3'd2, 2'b00, "R7");
    // R8 ROM and gaps
    access(24'hC00000, 3'd6, 2'b00, "R8");
    access(24'hC0FFFF, 3'd5, 2'b00, "R8");
    access(24'hC10000, 3'd5, 2'b00, "R8");
    access(24'hBFFFFF, 3'd5, 2'b00, "R8");
    access(24'hFFFFFE, 3'd5, 2'b00, "R8");
    // R9 boot override on both flag settings
    for (int m = 0; m < 2; m++) begin
      map_low = m[0];
      for (int b = 0; b < 4; b++) begin
        access(24'h000000, 3'd6, b[1:0], "R9");
        access(24'h000004, 3'd6, b[1:0], "R9");
        access(24'h000007, 3'd6, b[1:0], "R9");
      end
    end
    // R10 override ignored
    map_low = 1'b0;
    access(24'h000000, 3'd5, 2'b01, "R10");
    access(24'h000004, 3'd5, 2'b10, "R10");
    access(24'h000008, 3'd6, 2'b01, "R10");
    access(24'h00000C, 3'd6, 2'b10, "R10");
    // R2 interrupt acknowledge
    access(24'h000000, 3'd7, 2'b01, "R2");
    access(24'hFFFFFE, 3'd7, 2'b00, "R2");
    access(24'hC00000, 3'd7, 2'b00, "R2");
    // R1 strobe idle
    drive(24'h040000, 3'd5, 1'b1, 2'b00, "R1");
    drive(24'h000000, 3'd6, 1'b1, 2'b01, "R1");
    drive(24'hC00000, 3'd5, 1'b1, 2'b00, "R1");
    // R11 flag frozen during a long active strobe
    map_low = 1'b0;
    drive(24'h000000, 3'd5, 1'b1, 2'b00, "R11");
    drive(24'h000000, 3'd5, 1'b0, 2'b00, "R11");
    map_low = 1'b1;
    drive(24'h000000, 3'd5, 1'b0, 2'b00, "R11");   // still SRAM
    drive(24'h000000, 3'd5, 1'b0, 2'b00, "R11");
    drive(24'h000000, 3'd5, 1'b1, 2'b00, "R11");   // captured here
    drive(24'h000000, 3'd5, 1'b0, 2'b00, "R11");   // now mailbox
    map_low = 1'b0;
    drive(24'h000000, 3'd5, 1'b0, 2'b00, "R11");
    // R4 mixed traffic, every cycle compared
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] a;
      case ($urandom % 8)
        0: a = 24'($urandom % 16);
        1: a = 24'h000000 | 24'($urandom % 32'h1000);
        2: a = 24'h07F000 | 24'($urandom % 32'h2000);
        3: a = 24'h080000 | 24'($urandom % 32'h11000);
        4: a = 24'hBFF000 | 24'($urandom % 32'h12000);
        default: a = 24'($urandom);
      endcase
      map_low = 1'($urandom);
      drive(a, 3'($urandom), 1'(($urandom % 4) == 0), 2'($urandom), "R4");
    end
    finish_run();
  end
endmodule